// File: doc/BRIEF.md
# Bus DMA Address Translator

This block turns addresses issued by bus masters for DMA into system physical addresses. Four programmable windows cover the 32-bit part of the bus address space. Each window has a base, a size mask and a translated base. A window maps its range either directly onto a physical region or page by page, through a table of 64-bit entries kept in system memory. Two further mappings serve 64-bit bus addresses. The first is a large pass-through region that exposes the low 35 bits of the address unchanged. The second is a paged mode of the last window that covers a fixed 8 TB range. A control bit can also blank out a low-memory hole so that it never matches.

Software programs the windows through a simple indexed 64-bit register port. Translation requests arrive one at a time over a valid/ready handshake. Each response is a single-cycle pulse that carries a hit flag, the physical address and a mask of the address bits that pass through unchanged. A paged lookup issues exactly one read on the table port and holds it until the read data returns.

Top module: `dma_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and pt_req_o are 0, window 3 base reads 0x2 and every other register reads 0.
- R2: Register index map: 0..3 window bases, 4..7 masks, 8..11 translated bases, 12 control. Other indices read 0 and ignore writes. Bases 0..2 keep the bits 0xFFF00003. Base 3 keeps the bits 0x80FFF00001 and always reads bit 1 as 1. Masks keep 0xFFF00000 and translated bases keep 0x7FFFFFC00. A control write changes only the bits 0x1CFF0FC7FF.
- R3: A 32-bit address (bits 63:32 zero) hits window w when base bit 0 is set and (addr AND NOT ext) equals base AND 0xFFF00000, where ext = mask OR 0xFFFFF. Windows are tried in the order 0, 1, 2, 3 and the lowest-numbered hit wins.
- R4: A direct hit (base bit 1 clear) returns hit=1, address (tbase AND NOT ext) OR (addr AND ext), and mask ext.
- R5: A paged hit (base bit 1 set) reads the table entry at (tbase AND NOT (mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). A valid entry (bit 0 = 1) returns hit=1, address ((entry AND 0x3FFFFE)<<12) OR addr[12:0], and mask 0x1FFF.
- R6: A table entry with bit 0 clear gives a fault.
- R7: When control bit 5 is set, a 32-bit address in 0x80000..0xFFFFF faults whatever the windows hold.
- R8: When base 3 bit 39 (64-bit mode) is set, window 3 takes no part in 32-bit lookups.
- R9: When control bit 6 is set, an address in [2^40, 2^41) returns hit=1, address addr[34:0] and mask 0x7FFFFFFFF. When the bit is clear, such an address faults.
- R10: An address in 0x800_0000_0000..0xFFF_FFFF_FFFF, with base 3 bits 0 and 39 both set, reads the entry at (tbase3 AND 0x7FFC00000) OR ((addr AND 0xFFFFE000)>>10). It then resolves as in R5 and R6.
- R11: A fault returns hit=0, address 0 and mask 0. This covers any address that matches nothing.
- R12: A direct or fault response pulses rsp_valid_o in the cycle after acceptance. A paged response pulses it in the cycle after pt_rvalid_i. While the table read is pending, pt_req_o stays high with a stable address and req_ready_o is low.
- R13: A request accepted in the same cycle as a register write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_idx_i |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Ready for a request |
| req_addr_i | input | 64 | Bus address to translate |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | 1 = translated, 0 = fault |
| rsp_addr_o | output | 35 | Physical address |
| rsp_mask_o | output | 35 | Pass-through offset mask |
| pt_req_o | output | 1 | Table read pending |
| pt_addr_o | output | 35 | Table entry address |
| pt_rvalid_i | input | 1 | Table read data valid |
| pt_rdata_i | input | 64 | Table entry |

## Verification
A register write and a translation acceptance can fall in the same clock edge. The bench drives both at once: it disables window 0 while it sends an address that window 0 maps. It then expects the translation from window 0, and a follow-up request for the same address must fall through to the overlapping window 2. Table reads also overlap register traffic: the bench expects the pending table address to stay stable and the response to resolve only from the returned entry.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
  localparam int DW     = 64;
  localparam int PA_W   = 35;
  localparam int RIDX_W = 4;
  localparam int NWIN   = 4;
  localparam int OFF_W  = 13;

  localparam logic [DW-1:0] BASE_KEEP  = 64'h0000_0000_FFF0_0003;
  localparam logic [DW-1:0] BASE3_KEEP = 64'h0000_0080_FFF0_0001;
  localparam logic [DW-1:0] MASK_KEEP  = 64'h0000_0000_FFF0_0000;
  localparam logic [DW-1:0] TBASE_KEEP = 64'h0000_0007_FFFF_FC00;
  localparam logic [DW-1:0] CTRL_KEEP  = 64'h0000_001C_FF0F_C7FF;

  localparam int DAC_BIT  = 39;
  localparam int HOLE_BIT = 5;
  localparam int PASS_BIT = 6;
  localparam logic [RIDX_W-1:0] CTRL_IDX = RIDX_W'(3 * NWIN);

  localparam logic [31:0]     HOLE_LO   = 32'h0008_0000;
  localparam logic [31:0]     HOLE_HI   = 32'h000F_FFFF;
  localparam logic [PA_W-1:0] PAGE_MASK = PA_W'((1 << OFF_W) - 1);
  localparam logic [PA_W-1:0] DAC_TB    = 35'h7_FFC0_0000;

  typedef enum logic [1:0] {RES_FAULT, RES_DIRECT, RES_TABLE} res_kind_e;

  typedef struct packed {
    res_kind_e       kind;
    logic [PA_W-1:0] pa;    // physical address, or entry address for RES_TABLE
    logic [PA_W-1:0] mask;
  } xres_t;
endpackage

// File: rtl/dma_xlate_regs.sv
module dma_xlate_regs
  import dma_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     base_o  [NWIN],
  output logic [DW-1:0]     mask_o  [NWIN],
  output logic [DW-1:0]     tbase_o [NWIN],
  output logic [DW-1:0]     ctrl_o
);
  logic [DW-1:0] base_q  [NWIN];
  logic [DW-1:0] mask_q  [NWIN];
  logic [DW-1:0] tbase_q [NWIN];
  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWIN; w++) begin
        base_q[w]  <= (w == NWIN - 1) ? 64'h2 : '0;
        mask_q[w]  <= '0;
        tbase_q[w] <= '0;
      end
      ctrl_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < NWIN; w++) begin
        if (idx_i == RIDX_W'(w)) begin
          if (w == NWIN - 1) base_q[w] <= (wdata_i & BASE3_KEEP) | 64'h2;
          else               base_q[w] <= wdata_i & BASE_KEEP;
        end
        if (idx_i == RIDX_W'(NWIN + w))     mask_q[w]  <= wdata_i & MASK_KEEP;
        if (idx_i == RIDX_W'(2 * NWIN + w)) tbase_q[w] <= wdata_i & TBASE_KEEP;
      end
      if (idx_i == CTRL_IDX) ctrl_q <= (ctrl_q & ~CTRL_KEEP) | (wdata_i & CTRL_KEEP);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (idx_i == RIDX_W'(w))            rdata_o = base_q[w];
      if (idx_i == RIDX_W'(NWIN + w))     rdata_o = mask_q[w];
      if (idx_i == RIDX_W'(2 * NWIN + w)) rdata_o = tbase_q[w];
    end
    if (idx_i == CTRL_IDX) rdata_o = ctrl_q;
  end

  assign base_o  = base_q;
  assign mask_o  = mask_q;
  assign tbase_o = tbase_q;
  assign ctrl_o  = ctrl_q;

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && idx_i == CTRL_IDX) |=> $stable(ctrl_q));
  p_ctrl_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && idx_i == CTRL_IDX |=> (ctrl_q & ~CTRL_KEEP) == ($past(ctrl_q) & ~CTRL_KEEP));
  p_win3_paged_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q[NWIN-1][1]);
endmodule

// File: rtl/dma_xlate_win.sv
module dma_xlate_win
  import dma_xlate_pkg::*;
(
  input  logic            en_i,
  input  logic            sg_i,
  input  logic [11:0]     base_hi_i,
  input  logic [31:0]     mask_i,
  input  logic [PA_W-1:0] tbase_i,
  input  logic [31:0]     addr_i,
  output logic            hit_o,
  output xres_t           res_o
);
  logic [31:0]     ext;
  logic [PA_W-1:0] direct_pa;
  logic [PA_W-1:0] pte_pa;

  assign ext       = mask_i | 32'h000F_FFFF;
  assign hit_o     = en_i && ((addr_i & ~ext) == {base_hi_i, 20'h0});
  assign direct_pa = (tbase_i & ~PA_W'(ext)) | PA_W'(addr_i & ext);
  // entry index grows with the window size selected by the mask
  assign pte_pa    = (tbase_i & ~PA_W'(mask_i >> 10))
                   | PA_W'((addr_i & (mask_i | 32'h000F_E000)) >> 10);

  always_comb begin
    if (sg_i) begin
      res_o.kind = RES_TABLE;
      res_o.pa   = pte_pa;
      res_o.mask = PAGE_MASK;
    end else begin
      res_o.kind = RES_DIRECT;
      res_o.pa   = direct_pa;
      res_o.mask = PA_W'(ext);
    end
  end
endmodule

// File: rtl/dma_xlate_dec.sv
module dma_xlate_dec
  import dma_xlate_pkg::*;
(
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] base_i  [NWIN],
  input  logic [DW-1:0] mask_i  [NWIN],
  input  logic [DW-1:0] tbase_i [NWIN],
  input  logic [DW-1:0] ctrl_i,
  output xres_t         res_o
);
  logic [NWIN-1:0] win_hit;
  xres_t           win_res [NWIN];
  logic            sac, in_hole, in_pass, in_dac, dac_mode;
  logic            unused_dec;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    dma_xlate_win u_win (
      .en_i      (base_i[w][0]),
      .sg_i      (base_i[w][1]),
      .base_hi_i (base_i[w][31:20]),
      .mask_i    (mask_i[w][31:0]),
      .tbase_i   (tbase_i[w][PA_W-1:0]),
      .addr_i    (addr_i[31:0]),
      .hit_o     (win_hit[w]),
      .res_o     (win_res[w])
    );
  end

  assign sac      = (addr_i[63:32] == '0);
  assign in_hole  = ctrl_i[HOLE_BIT] && addr_i[31:0] >= HOLE_LO && addr_i[31:0] <= HOLE_HI;
  assign in_pass  = (addr_i[63:41] == '0) && addr_i[40];
  assign in_dac   = (addr_i[63:44] == '0) && addr_i[43];
  assign dac_mode = base_i[NWIN-1][DAC_BIT];

  always_comb begin
    res_o = '{kind: RES_FAULT, pa: '0, mask: '0};
    if (sac) begin
      if (!in_hole) begin
        // descending walk: the lowest-numbered hit is written last
        for (int w = NWIN - 1; w >= 0; w--) begin
          if (win_hit[w] && !(w == NWIN - 1 && dac_mode)) res_o = win_res[w];
        end
      end
    end else if (in_pass && ctrl_i[PASS_BIT]) begin
      res_o = '{kind: RES_DIRECT, pa: addr_i[PA_W-1:0], mask: '1};
    end else if (in_dac && base_i[NWIN-1][0] && dac_mode) begin
      res_o.kind = RES_TABLE;
      res_o.pa   = (tbase_i[NWIN-1][PA_W-1:0] & DAC_TB)
                 | PA_W'({addr_i[31:13], 13'h0} >> 10);
      res_o.mask = PAGE_MASK;
    end
  end

  always_comb begin
    unused_dec = 1'b0;
    for (int w = 0; w < NWIN; w++)
      unused_dec = unused_dec ^ (^base_i[w]) ^ (^mask_i[w]) ^ (^tbase_i[w]);
    unused_dec = unused_dec ^ (^ctrl_i);
  end
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dma_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RIDX_W-1:0] reg_idx_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DW-1:0]     req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [PA_W-1:0]   rsp_addr_o,
  output logic [PA_W-1:0]   rsp_mask_o,
  output logic              pt_req_o,
  output logic [PA_W-1:0]   pt_addr_o,
  input  logic              pt_rvalid_i,
  input  logic [DW-1:0]     pt_rdata_i
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  logic [DW-1:0]    base  [NWIN];
  logic [DW-1:0]    mask  [NWIN];
  logic [DW-1:0]    tbase [NWIN];
  logic [DW-1:0]    ctrl;
  xres_t            dec_res;
  st_e              state_q;
  logic             accept;
  logic             rsp_valid_q, rsp_hit_q;
  logic [PA_W-1:0]  rsp_addr_q, rsp_mask_q, pt_addr_q;
  logic [OFF_W-1:0] off_q;
  logic             unused_rdata;

  dma_xlate_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base),
    .mask_o  (mask),
    .tbase_o (tbase),
    .ctrl_o  (ctrl)
  );

  dma_xlate_dec u_dec (
    .addr_i  (req_addr_i),
    .base_i  (base),
    .mask_i  (mask),
    .tbase_i (tbase),
    .ctrl_i  (ctrl),
    .res_o   (dec_res)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_mask_q  <= '0;
      pt_addr_q   <= '0;
      off_q       <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          off_q <= req_addr_i[OFF_W-1:0];
          if (dec_res.kind == RES_TABLE) begin
            pt_addr_q <= dec_res.pa;
            state_q   <= ST_WAIT;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= (dec_res.kind == RES_DIRECT);
            rsp_addr_q  <= dec_res.pa;
            rsp_mask_q  <= dec_res.mask;
          end
        end
        ST_WAIT: if (pt_rvalid_i) begin
          rsp_valid_q <= 1'b1;
          state_q     <= ST_IDLE;
          if (pt_rdata_i[0]) begin
            rsp_hit_q  <= 1'b1;
            rsp_addr_q <= PA_W'({pt_rdata_i[21:1], off_q});
            rsp_mask_q <= PAGE_MASK;
          end else begin
            rsp_hit_q  <= 1'b0;
            rsp_addr_q <= '0;
            rsp_mask_q <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_hit_o    = rsp_hit_q;
  assign rsp_addr_o   = rsp_addr_q;
  assign rsp_mask_o   = rsp_mask_q;
  assign pt_req_o     = (state_q == ST_WAIT);
  assign pt_addr_o    = pt_addr_q;
  assign unused_rdata = ^pt_rdata_i[DW-1:22];

  p_busy_not_ready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_req_o |-> !req_ready_o);
  p_pt_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_req_o && !pt_rvalid_i |=> pt_req_o && $stable(pt_addr_o));
  p_fault_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> rsp_addr_o == '0 && rsp_mask_o == '0);
  p_offset_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> rsp_addr_o[OFF_W-1:0] == off_q);
  p_hole_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ctrl[HOLE_BIT] && req_addr_i[63:32] == '0
      && req_addr_i[31:0] >= HOLE_LO && req_addr_i[31:0] <= HOLE_HI
    |=> rsp_valid_o && !rsp_hit_o);
endmodule

// File: tb/dma_xlate_test.sv
module dma_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [34:0] rsp_addr, rsp_mask;
  logic        pt_req;
  logic [34:0] pt_addr;
  logic        pt_rvalid = 1'b0;
  logic [63:0] pt_rdata = '0;

  int errors = 0;
  int checks = 0;

  logic [63:0] sh_base [4];
  logic [63:0] sh_mask [4];
  logic [63:0] sh_tb   [4];
  logic [63:0] sh_ctrl;

  always #5 clk = ~clk;

  dma_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_addr_o(rsp_addr), .rsp_mask_o(rsp_mask),
    .pt_req_o(pt_req), .pt_addr_o(pt_addr), .pt_rvalid_i(pt_rvalid), .pt_rdata_i(pt_rdata)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] shadow_of(input int idx);
    if (idx < 4)  return sh_base[idx];
    if (idx < 8)  return sh_mask[idx-4];
    if (idx < 12) return sh_tb[idx-8];
    if (idx == 12) return sh_ctrl;
    return 64'h0;
  endfunction

  // R2 register semantics, applied to the bench copy
  function automatic void apply(input int idx, input logic [63:0] v);
    if (idx < 3)       sh_base[idx] = v & 64'hFFF0_0003;
    else if (idx == 3) sh_base[3] = (v & 64'h80_FFF0_0001) | 64'h2;
    else if (idx < 8)  sh_mask[idx-4] = v & 64'hFFF0_0000;
    else if (idx < 12) sh_tb[idx-8] = v & 64'h7_FFFF_FC00;
    else if (idx == 12) sh_ctrl = (sh_ctrl & ~64'h1C_FF0F_C7FF) | (v & 64'h1C_FF0F_C7FF);
  endfunction

  task automatic wreg(input int idx, input logic [63:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    apply(idx, v);
  endtask

  task automatic rreg(input int idx, input string rq);
    @(negedge clk);
    reg_idx = 4'(idx);
    #1;
    chk(rq, reg_rdata, shadow_of(idx));
  endtask

  // kind: 0 fault, 1 direct, 2 table (pa holds the entry address)
  function automatic void model(input logic [63:0] a, output int k,
                                output logic [34:0] pa, output logic [34:0] mk);
    k = 0; pa = '0; mk = '0;
    if (a[63:32] == '0) begin
      if (sh_ctrl[5] && a >= 64'h80000 && a <= 64'hFFFFF) return;
      for (int w = 0; w < 4; w++) begin
        logic [63:0] ext;
        ext = sh_mask[w] | 64'hFFFFF;
        if (w == 3 && sh_base[3][39]) continue;
        if (sh_base[w][0] && ((a & ~ext) == (sh_base[w] & 64'hFFF0_0000))) begin
          if (sh_base[w][1]) begin
            k = 2;
            pa = 35'((sh_tb[w] & ~(sh_mask[w] >> 10)) | ((a & (sh_mask[w] | 64'hFE000)) >> 10));
            mk = 35'h1FFF;
          end else begin
            k = 1;
            pa = 35'((sh_tb[w] & ~ext) | (a & ext));
            mk = 35'(ext);
          end
          return;
        end
      end
    end else if (a >= 64'h100_0000_0000 && a < 64'h200_0000_0000 && sh_ctrl[6]) begin
      k = 1; pa = a[34:0]; mk = '1;
    end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF && sh_base[3][0] && sh_base[3][39]) begin
      k = 2;
      pa = 35'((sh_tb[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10));
      mk = 35'h1FFF;
    end
  endfunction

  function automatic logic [63:0] ent(input logic [34:0] p);
    logic [31:0] v;
    v = p[34:3] * 32'h9E37_79B1;
    return {v[31:10], 20'hABCDE, v[21:0]};
  endfunction

  task automatic xlate(input logic [63:0] a);
    int k; logic [34:0] epa, emk; logic [63:0] e;
    model(a, k, epa, emk);
    @(negedge clk);
    chk("R12 ready idle", 64'(req_ready), 64'h1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (k != 2) begin
      chk("R12 rsp_valid direct", 64'(rsp_valid), 64'h1);
      chk(k == 1 ? "R4 hit" : "R11 fault hit", 64'(rsp_hit), 64'(k == 1));
      chk(k == 1 ? "R4 addr" : "R11 fault addr", 64'(rsp_addr), 64'(epa));
      chk(k == 1 ? "R4 mask" : "R11 fault mask", 64'(rsp_mask), 64'(emk));
    end else begin
      chk("R12 pt_req", 64'(pt_req), 64'h1);
      chk("R5 R10 entry addr", 64'(pt_addr), 64'(epa));
      chk("R12 not ready while waiting", 64'(req_ready), 64'h0);
      e = ent(pt_addr);
      repeat (2) begin
        @(negedge clk);
        chk("R12 no early rsp", 64'(rsp_valid), 64'h0);
        chk("R12 pt_addr stable", 64'(pt_addr), 64'(epa));
      end
      pt_rvalid = 1'b1; pt_rdata = e;
      @(negedge clk);
      pt_rvalid = 1'b0; pt_rdata = '0;
      chk("R12 rsp after table", 64'(rsp_valid), 64'h1);
      chk("R12 pt released", 64'(pt_req), 64'h0);
      if (e[0]) begin
        chk("R5 hit", 64'(rsp_hit), 64'h1);
        chk("R5 addr", 64'(rsp_addr), 64'(35'(((e & 64'h3FFFFE) << 12) | 64'(a[12:0]))));
        chk("R5 mask", 64'(rsp_mask), 64'h1FFF);
      end else begin
        chk("R6 invalid hit", 64'(rsp_hit), 64'h0);
        chk("R6 invalid addr", 64'(rsp_addr), 64'h0);
        chk("R6 invalid mask", 64'(rsp_mask), 64'h0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k; logic [34:0] epa, emk;
    for (int w = 0; w < 4; w++) begin
      sh_base[w] = (w == 3) ? 64'h2 : 64'h0; sh_mask[w] = '0; sh_tb[w] = '0;
    end
    sh_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 ready", 64'(req_ready), 64'h1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R1 pt_req", 64'(pt_req), 64'h0);
    for (int i = 0; i < 14; i++) rreg(i, "R1 reset value");

    // R2 write masks and index map
    for (int i = 0; i < 14; i++) begin
      wreg(i, 64'hFFFF_FFFF_FFFF_FFFF);
      rreg(i, "R2 ones readback");
    end
    for (int i = 0; i < 14; i++) begin
      wreg(i, 64'h0);
      rreg(i, "R2 zero readback");
    end
    rreg(3, "R2 base3 paged bit");

    // windows: w0 direct 1MB, w1 paged 4MB, w2 direct 16MB under both, w3 paged
    wreg(0, 64'h0010_0001); wreg(4, 64'h0);         wreg(8,  64'h4_0000_0000);
    wreg(1, 64'h0040_0003); wreg(5, 64'h0030_0000); wreg(9,  64'h1_2340_0000);
    wreg(2, 64'h0000_0001); wreg(6, 64'h00F0_0000); wreg(10, 64'h2_0000_0000);
    wreg(3, 64'h0100_0001); wreg(7, 64'h0);         wreg(11, 64'h3_5550_0000);

    // R3 R4 R5 R6 R11 sweep
    for (int i = 0; i < 300; i++) xlate(64'(i) * 64'h1_1F01);
    // R3 priority and window edges
    xlate(64'h7_FFFF); xlate(64'h8_0000); xlate(64'hF_FFFF); xlate(64'h10_0000);
    xlate(64'h1F_FFFF); xlate(64'h20_0000); xlate(64'h3F_FFFF); xlate(64'h40_0000);
    xlate(64'h7F_FFFF); xlate(64'h80_0000); xlate(64'hFF_FFFF); xlate(64'h100_0000);
    xlate(64'h10F_FFFF); xlate(64'h110_0000); xlate(64'hFFFF_FFFF);
    xlate(64'h100_0000_1234); xlate(64'h800_0000_4000); // R9 R10 disabled: R11

    // R7 hole
    wreg(12, 64'h20);
    xlate(64'h7_FFFF); xlate(64'h8_0000); xlate(64'hC_1234); xlate(64'hF_FFFF); xlate(64'h10_0000);

    // R8 R9 R10: window 3 in 64-bit mode, pass-through on
    wreg(3, 64'h80_0100_0001);
    wreg(12, 64'h60);
    xlate(64'h100_0000); xlate(64'h10F_FFFF); xlate(64'hFF_FFFF);
    xlate(64'h100_0000_0000); xlate(64'h1AB_CDEF_1234); xlate(64'h1FF_FFFF_FFFF);
    xlate(64'hFF_FFFF_FFFF); xlate(64'h200_0000_0000);
    for (int i = 0; i < 40; i++) xlate(64'h800_0000_0000 + 64'(i) * 64'h3_3B5C_7A13);
    xlate(64'hFFF_FFFF_FFFF); xlate(64'h1000_0000_0000);
    wreg(12, 64'h20);
    xlate(64'h100_0000_1234); // R9 off

    // R13 write and accept in one cycle: old window 0 still applies
    model(64'h12_3456, k, epa, emk);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 4'd0; reg_wdata = 64'h0;
    req_valid = 1'b1; req_addr = 64'h12_3456;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    apply(0, 64'h0);
    chk("R13 rsp_valid", 64'(rsp_valid), 64'h1);
    chk("R13 old hit", 64'(rsp_hit), 64'(k == 1));
    chk("R13 old addr", 64'(rsp_addr), 64'(epa));
    chk("R13 old mask", 64'(rsp_mask), 64'(emk));
    xlate(64'h12_3456); // R13 new value: falls to window 2

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule